// File: doc/BRIEF.md
# Interleaved Group Parity Encoder

This block stands in front of an associative (content-addressable) memory and turns every data word into a codeword before the word reaches the memory. The block is used both for stored words and for search keys. It adds one even-parity bit per interleave group. Data bit `i` belongs to group `i mod GROUPS`. A stored word that suffers an upset of up to `GROUPS` adjacent bits becomes a non-codeword. A search key is always a valid codeword, so a corrupted entry can miss a search but can never falsely match one. The memory itself needs no change.

A second path takes a full codeword, for example one read back during a scrub pass. That path recomputes the group parities and reports which groups disagree. Any mismatch raises an error flag. Both paths are registered with a latency of one cycle, and each has a valid signal that follows its input valid.

Top module: `igp_encoder`

## Requirements
- R1: While reset is high and on the first cycle after it, `enc_valid_o`, `chk_valid_o` and `chk_err_o` are low, and `enc_word_o` and `chk_grp_o` are all zeros.
- R2: `enc_valid_o` equals `enc_valid_i` of the previous cycle, and `chk_valid_o` equals `chk_valid_i` of the previous cycle. Each accepted input produces exactly one result.
- R3: One cycle after a valid encode input, `enc_word_o[DATA_W-1:0]` equals the data word that was presented.
- R4: One cycle after a valid encode input, `enc_word_o[DATA_W+g]` is the XOR of every data bit whose index modulo `GROUPS` equals `g`, which gives even parity per group. Parity group 0 sits lowest, directly above the data. Because `DATA_W` is a multiple of `GROUPS`, every codeword bit `p` belongs to group `p mod GROUPS`.
- R5: While `enc_valid_i` is low, `enc_word_o` holds its previous value, whatever `enc_data_i` carries.
- R6: One cycle after a valid check input, bit `g` of `chk_grp_o` is set exactly when group `g` of `chk_word_i` has odd parity. `chk_err_o` is high when any bit of `chk_grp_o` is set.
- R7: A word produced by the encoder and fed back to the check input gives `chk_err_o` low and `chk_grp_o` zero.
- R8: Any codeword in which 1 to `GROUPS` adjacent bits are inverted, at any position in the full `DATA_W+GROUPS` word, gives `chk_err_o` high.
- R9: One cycle after `chk_valid_i` is low, `chk_err_o` is low and `chk_grp_o` is zero, whatever `chk_word_i` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enc_valid_i | input | 1 | Encode request valid |
| enc_data_i | input | DATA_W | Data word to encode |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_word_o | output | DATA_W+GROUPS | Codeword: data low, group parities high |
| chk_valid_i | input | 1 | Check request valid |
| chk_word_i | input | DATA_W+GROUPS | Codeword to check |
| chk_valid_o | output | 1 | Check result valid |
| chk_err_o | output | 1 | Non-codeword detected |
| chk_grp_o | output | GROUPS | Per-group mismatch flags |

## Verification
The encoder is driven with all-zero and all-one words, with single bits placed in each group, with alternating and nibble patterns, and with pseudo-random words. These patterns separate a wrong group assignment from a wrong bit order or a wrong parity sense. The checker receives clean codewords, to confirm that no error is reported falsely. It also receives codewords with bursts of one to four adjacent inverted bits at the low end, in the middle, across the boundary between data and parity, and at the top, which shows whether every burst within the interleave reach is caught and whether the syndrome names the right groups. Idle cycles with changing garbage on the data inputs show that held and cleared outputs do not depend on unqualified input.

// File: rtl/igp_pkg.sv
package igp_pkg;

    localparam int IGP_DATA_W_DEF = 32;
    localparam int IGP_GROUPS_DEF = 4;

    // group owning codeword bit position pos
    function automatic int grp_of(input int pos, input int groups);
        return pos % groups;
    endfunction

endpackage

// File: rtl/igp_parity_gen.sv
module igp_parity_gen #(
    parameter int DW = igp_pkg::IGP_DATA_W_DEF,
    parameter int NG = igp_pkg::IGP_GROUPS_DEF
) (
    input  logic [DW-1:0] data_i,
    output logic [NG-1:0] par_o
);

    for (genvar g = 0; g < NG; g++) begin : g_grp
        always_comb begin
            logic acc;
            acc = 1'b0;
            for (int i = 0; i < DW; i++) begin
                if (igp_pkg::grp_of(i, NG) == g) acc = acc ^ data_i[i];
            end
            par_o[g] = acc;
        end
    end

endmodule

// File: rtl/igp_encode_stage.sv
module igp_encode_stage #(
    parameter int DW = igp_pkg::IGP_DATA_W_DEF,
    parameter int NG = igp_pkg::IGP_GROUPS_DEF,
    localparam int CW = DW + NG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [DW-1:0] data_i,
    output logic          valid_o,
    output logic [CW-1:0] word_o
);

    logic [NG-1:0] par;

    igp_parity_gen #(.DW(DW), .NG(NG)) u_gen (
        .data_i (data_i),
        .par_o  (par)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            word_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) word_o <= {par, data_i};
        end
    end

    AST_ENC_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> (word_o[DW-1:0] == $past(data_i))); // R3

    AST_ENC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(word_o)); // R5

endmodule

// File: rtl/igp_check_stage.sv
module igp_check_stage #(
    parameter int DW = igp_pkg::IGP_DATA_W_DEF,
    parameter int NG = igp_pkg::IGP_GROUPS_DEF,
    localparam int CW = DW + NG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [CW-1:0] word_i,
    output logic          valid_o,
    output logic          err_o,
    output logic [NG-1:0] grp_o
);

    logic [NG-1:0] recomputed;
    logic [NG-1:0] syndrome;

    igp_parity_gen #(.DW(DW), .NG(NG)) u_gen (
        .data_i (word_i[DW-1:0]),
        .par_o  (recomputed)
    );

    assign syndrome = recomputed ^ word_i[CW-1:DW];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            grp_o   <= '0;
        end else begin
            valid_o <= valid_i;
            err_o   <= valid_i && (syndrome != '0);
            grp_o   <= valid_i ? syndrome : '0;
        end
    end

    AST_CHK_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!err_o && grp_o == '0)); // R9

endmodule

// File: rtl/igp_encoder.sv
module igp_encoder #(
    parameter int DATA_W = igp_pkg::IGP_DATA_W_DEF,
    parameter int GROUPS = igp_pkg::IGP_GROUPS_DEF,
    localparam int CODE_W = DATA_W + GROUPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [CODE_W-1:0] enc_word_o,
    input  logic              chk_valid_i,
    input  logic [CODE_W-1:0] chk_word_i,
    output logic              chk_valid_o,
    output logic              chk_err_o,
    output logic [GROUPS-1:0] chk_grp_o
);

    igp_encode_stage #(.DW(DATA_W), .NG(GROUPS)) u_enc (
        .clk     (clk),
        .rst     (rst),
        .valid_i (enc_valid_i),
        .data_i  (enc_data_i),
        .valid_o (enc_valid_o),
        .word_o  (enc_word_o)
    );

    igp_check_stage #(.DW(DATA_W), .NG(GROUPS)) u_chk (
        .clk     (clk),
        .rst     (rst),
        .valid_i (chk_valid_i),
        .word_i  (chk_word_i),
        .valid_o (chk_valid_o),
        .err_o   (chk_err_o),
        .grp_o   (chk_grp_o)
    );

    AST_ENC_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        enc_valid_i |=> enc_valid_o); // R2

    AST_ENC_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !enc_valid_i |=> !enc_valid_o); // R2

    AST_CHK_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        chk_valid_i |=> chk_valid_o); // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!enc_valid_o && !chk_valid_o && !chk_err_o)); // R1

endmodule

// File: tb/sim_igp_encoder.sv
module sim_igp_encoder;

    localparam int DW = 32;
    localparam int NG = 4;
    localparam int CW = DW + NG;

    typedef struct {
        logic [CW-1:0] word;
        string         tag;
    } enc_item_t;

    typedef struct {
        logic          err;
        logic [NG-1:0] grp;
        string         tag;
    } chk_item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enc_valid_i = 1'b0;
    logic [DW-1:0] enc_data_i = '0;
    logic          enc_valid_o;
    logic [CW-1:0] enc_word_o;
    logic          chk_valid_i = 1'b0;
    logic [CW-1:0] chk_word_i = '0;
    logic          chk_valid_o;
    logic          chk_err_o;
    logic [NG-1:0] chk_grp_o;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    bit done = 1'b0;
    bit have_last = 1'b0;
    logic [CW-1:0] last_word;

    enc_item_t enc_q[$];
    chk_item_t chk_q[$];

    always #4 clk = ~clk;

    igp_encoder #(.DATA_W(DW), .GROUPS(NG)) u0 (
        .clk         (clk),
        .rst         (rst),
        .enc_valid_i (enc_valid_i),
        .enc_data_i  (enc_data_i),
        .enc_valid_o (enc_valid_o),
        .enc_word_o  (enc_word_o),
        .chk_valid_i (chk_valid_i),
        .chk_word_i  (chk_word_i),
        .chk_valid_o (chk_valid_o),
        .chk_err_o   (chk_err_o),
        .chk_grp_o   (chk_grp_o)
    );

    function automatic logic [NG-1:0] ref_par(input logic [DW-1:0] d);
        logic [NG-1:0] p = '0;
        for (int i = 0; i < DW; i++) p[i % NG] = p[i % NG] ^ d[i];
        return p;
    endfunction

    function automatic logic [CW-1:0] ref_code(input logic [DW-1:0] d);
        return {ref_par(d), d};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic enc_send(input logic [DW-1:0] d, input string tag);
        enc_item_t it;
        @(negedge clk);
        enc_valid_i = 1'b1;
        enc_data_i  = d;
        it.word = ref_code(d);
        it.tag  = tag;
        enc_q.push_back(it);
    endtask

    task automatic enc_idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            enc_valid_i = 1'b0;
            enc_data_i  = $urandom();
        end
    endtask

    task automatic chk_send(input logic [CW-1:0] w, input string tag);
        chk_item_t it;
        logic [NG-1:0] s;
        @(negedge clk);
        chk_valid_i = 1'b1;
        chk_word_i  = w;
        s = ref_par(w[DW-1:0]) ^ w[CW-1:DW];
        it.grp = s;
        it.err = (s != '0);
        it.tag = tag;
        chk_q.push_back(it);
    endtask

    task automatic chk_idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk_valid_i = 1'b0;
            chk_word_i  = {$urandom(), $urandom()};
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (started) begin
            if (enc_valid_o) begin
                if (enc_q.size() == 0) begin
                    check(1'b0, "R2 unexpected enc_valid_o", 64'(enc_valid_o), 64'd0);
                end else begin
                    enc_item_t e;
                    e = enc_q.pop_front();
                    check(enc_word_o == e.word, e.tag, 64'(enc_word_o), 64'(e.word));
                end
                last_word = enc_word_o;
                have_last = 1'b1;
            end else if (have_last) begin
                check(enc_word_o == last_word, "R5 hold", 64'(enc_word_o), 64'(last_word));
            end
            if (chk_valid_o) begin
                if (chk_q.size() == 0) begin
                    check(1'b0, "R2 unexpected chk_valid_o", 64'(chk_valid_o), 64'd0);
                end else begin
                    chk_item_t c;
                    c = chk_q.pop_front();
                    check(chk_err_o == c.err && chk_grp_o == c.grp, c.tag,
                          64'({chk_err_o, chk_grp_o}), 64'({c.err, c.grp}));
                end
            end else begin
                check(!chk_err_o && chk_grp_o == '0, "R9 idle clear",
                      64'({chk_err_o, chk_grp_o}), 64'd0);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] pats[$];
        logic [CW-1:0] base;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!enc_valid_o && !chk_valid_o && !chk_err_o && enc_word_o == '0 && chk_grp_o == '0,
              "R1 reset", 64'({enc_valid_o, chk_valid_o, chk_err_o, chk_grp_o}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!enc_valid_o && !chk_valid_o && !chk_err_o && enc_word_o == '0 && chk_grp_o == '0,
              "R1 after reset", 64'({enc_valid_o, chk_valid_o, chk_err_o, chk_grp_o}), 64'd0);
        started = 1'b1;

        pats.push_back('0);
        pats.push_back('1);
        pats.push_back(32'h0000_0001);
        pats.push_back(32'h0000_0002);
        pats.push_back(32'h0000_0004);
        pats.push_back(32'h8000_0000);
        pats.push_back(32'hAAAA_AAAA);
        pats.push_back(32'h0F0F_0F0F);
        pats.push_back(32'h1111_1111);
        for (int k = 0; k < 12; k++) pats.push_back($urandom());

        // R3 R4: encoding, back to back
        foreach (pats[k]) enc_send(pats[k], "R3/R4 encode");
        enc_idle(4);
        enc_send(32'h1234_5678, "R3/R4 encode after idle");
        enc_idle(3);

        // R7: clean codewords give no error
        foreach (pats[k]) chk_send(ref_code(pats[k]), "R7 clean codeword");
        chk_idle(2);

        // R8: adjacent bursts of 1..NG inverted bits
        base = ref_code(32'hC3A5_5A3C);
        for (int len = 1; len <= NG; len++) begin
            int starts[5];
            starts = '{0, 13, DW - 2, DW - 1, CW - len};
            foreach (starts[s]) begin
                logic [CW-1:0] mask = '0;
                for (int b = 0; b < len; b++) mask[starts[s] + b] = 1'b1;
                chk_send(base ^ mask, "R8 burst");
            end
        end
        chk_idle(1);

        // R6: arbitrary syndromes on parity and data
        chk_send(base ^ {4'b0101, 32'd0}, "R6 parity field corrupt");
        chk_send(base ^ {4'b0000, 32'h0000_0011}, "R6 same-group double flip");
        chk_send(base ^ {4'b1000, 32'h0000_0006}, "R6 three groups");
        chk_idle(4);

        repeat (2) @(negedge clk);
        check(enc_q.size() == 0 && chk_q.size() == 0, "R2 all results seen",
              64'(enc_q.size() + chk_q.size()), 64'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule